// File: doc/BRIEF.md
# Compact Branch Next-PC Unit

This unit resolves the control-transfer outcome of compact branches and jumps in a 32-bit core. These transfers have no delay slot. From the current program counter, the rs and rt register values, the rs field number, a decoded operation class and the 16-, 21- and 26-bit immediate fields, it produces four results:

- the next program counter;
- a redirect flag that tells fetch to abandon the sequential path;
- a link-write enable;
- the link value destined for register 31.

Four kinds of transfer are covered:

- an unconditional PC-relative branch;
- the same branch with link;
- a shared opcode that acts either as branch-if-zero with a 21-bit offset or as a register-indirect jump, depending on whether the rs field is zero;
- a second register-indirect jump opcode, which links when the decoder flags its linking variant.

No delay slot exists, so every link value is the address of the transfer plus four, never plus eight.

Results are computed in one combinational stage and captured in a single register stage. All outputs therefore describe the inputs presented on the previous rising clock edge.

Top module: `cbr_next_pc`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released, `next_pc`, `redirect`, `link_we` and `link_val` read zero.
- R2: Class 3'd1 (unconditional branch) gives `next_pc` = PC + 4 + (sign-extended `imm26` << 2), with `redirect` = 1 and `link_we` = 0.
- R3: Class 3'd2 (branch with link) gives the same target as R2, with `redirect` = 1 and `link_we` = 1. Outside reset, `link_val` always equals PC + 4 of the sampled transfer.
- R4: Class 3'd3 with `rs_num` nonzero and `rs_val` equal to zero is taken. It gives `next_pc` = PC + 4 + (sign-extended `imm21` << 2) and `redirect` = 1.
- R5: Class 3'd3 with `rs_num` nonzero and `rs_val` nonzero is not taken. It gives `next_pc` = PC + 4, `redirect` = 0 and `link_we` = 0.
- R6: Class 3'd3 with `rs_num` equal to zero jumps to `rt_val` + sign-extended `imm16`, with `redirect` = 1. `link_sel` has no effect, so `link_we` stays 0.
- R7: Class 3'd4 jumps to `rt_val` + sign-extended `imm16` with `redirect` = 1. `link_we` follows `link_sel`.
- R8: Class 3'd0 and classes 3'd5 to 3'd7 give `next_pc` = PC + 4, `redirect` = 0 and `link_we` = 0.
- R9: Each output changes only at a rising clock edge and reflects the inputs sampled at that edge.
- R10: Every target is formed modulo 2^32. Negative offsets, the most negative 26-bit offset and a PC near the top of the address space all wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_class | input | 3 | Decoded transfer class (0 none, 1 branch, 2 branch+link, 3 zero-test/jump, 4 jump) |
| link_sel | input | 1 | Linking variant of class 4 |
| cur_pc | input | 32 | Address of the transfer instruction |
| rs_val | input | 32 | Value read from the rs register |
| rt_val | input | 32 | Value read from the rt register |
| rs_num | input | 5 | rs field number |
| imm16 | input | 16 | 16-bit immediate |
| imm21 | input | 21 | 21-bit offset |
| imm26 | input | 26 | 26-bit offset |
| next_pc | output | 32 | Resolved next program counter |
| redirect | output | 1 | Transfer taken |
| link_we | output | 1 | Write link value to register 31 |
| link_val | output | 32 | Return address, PC + 4 |

## Verification
A linking transfer raises the redirect and the register-31 write in the same cycle. Both the target and the link value derive from the one sampled PC. The bench provokes this with branch-with-link and linking-jump vectors whose target lies far from PC + 4. In each case it judges that `next_pc` carries the target while `link_val` still carries PC + 4 and `link_we` is high. The opposite pairing is also covered: the shared-opcode jump with `link_sel` raised must redirect without writing the link.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    typedef enum logic [2:0] {
        CLS_NONE = 3'd0,
        CLS_BR   = 3'd1,
        CLS_BRL  = 3'd2,
        CLS_ZJ   = 3'd3,
        CLS_JX   = 3'd4
    } cls_e;

    localparam int INSTR_BYTES = 4;
    localparam int OFS_SHIFT   = 2;
endpackage

// File: rtl/cbr_sext.sv
module cbr_sext #(
    parameter int XLEN  = 32,
    parameter int IN_W  = 16,
    parameter int SHIFT = 0
) (
    input  logic [IN_W-1:0] imm,
    output logic [XLEN-1:0] val
);
    localparam int FILL_W = XLEN - IN_W;

    logic [XLEN-1:0] ext;

    generate
        if (FILL_W > 0) begin : g_fill
            assign ext = {{FILL_W{imm[IN_W-1]}}, imm};
        end else begin : g_trunc
            assign ext = imm[XLEN-1:0];
        end
    endgenerate

    assign val = ext << SHIFT;
endmodule

// File: rtl/cbr_target_gen.sv
module cbr_target_gen
    import cbr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int I16_W = 16,
    parameter int I21_W = 21,
    parameter int I26_W = 26
) (
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [I16_W-1:0] imm16,
    input  logic [I21_W-1:0] imm21,
    input  logic [I26_W-1:0] imm26,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  far_tgt,
    output logic [XLEN-1:0]  mid_tgt,
    output logic [XLEN-1:0]  reg_tgt
);
    logic [XLEN-1:0] ofs26, ofs21, ofs16;

    cbr_sext #(.XLEN(XLEN), .IN_W(I26_W), .SHIFT(OFS_SHIFT)) u_sx26 (.imm(imm26), .val(ofs26));
    cbr_sext #(.XLEN(XLEN), .IN_W(I21_W), .SHIFT(OFS_SHIFT)) u_sx21 (.imm(imm21), .val(ofs21));
    cbr_sext #(.XLEN(XLEN), .IN_W(I16_W), .SHIFT(0))         u_sx16 (.imm(imm16), .val(ofs16));

    assign seq_pc  = cur_pc + XLEN'(INSTR_BYTES);
    assign far_tgt = seq_pc + ofs26;
    assign mid_tgt = seq_pc + ofs21;
    assign reg_tgt = rt_val + ofs16;
endmodule

// File: rtl/cbr_resolve.sv
module cbr_resolve
    import cbr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RNUM_W = 5
) (
    input  logic [2:0]        op_class,
    input  logic              link_sel,
    input  logic [RNUM_W-1:0] rs_num,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   far_tgt,
    input  logic [XLEN-1:0]   mid_tgt,
    input  logic [XLEN-1:0]   reg_tgt,
    output logic              take,
    output logic              lnk,
    output logic [XLEN-1:0]   tgt
);
    cls_e cls;
    logic rs_field_zero;
    logic rs_value_zero;

    assign cls           = cls_e'(op_class);
    assign rs_field_zero = (rs_num == '0);
    assign rs_value_zero = (rs_val == '0);

    always_comb begin
        take = 1'b0;
        lnk  = 1'b0;
        tgt  = far_tgt;
        unique case (cls)
            CLS_BR: begin
                take = 1'b1;
            end
            CLS_BRL: begin
                take = 1'b1;
                lnk  = 1'b1;
            end
            CLS_ZJ: begin
                if (rs_field_zero) begin
                    take = 1'b1;
                    tgt  = reg_tgt;
                end else begin
                    take = rs_value_zero;
                    tgt  = mid_tgt;
                end
            end
            CLS_JX: begin
                take = 1'b1;
                lnk  = link_sel;
                tgt  = reg_tgt;
            end
            default: begin
                take = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cbr_next_pc.sv
module cbr_next_pc #(
    parameter int XLEN   = 32,
    parameter int RNUM_W = 5,
    parameter int I16_W  = 16,
    parameter int I21_W  = 21,
    parameter int I26_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_class,
    input  logic              link_sel,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   rt_val,
    input  logic [RNUM_W-1:0] rs_num,
    input  logic [I16_W-1:0]  imm16,
    input  logic [I21_W-1:0]  imm21,
    input  logic [I26_W-1:0]  imm26,
    output logic [XLEN-1:0]   next_pc,
    output logic              redirect,
    output logic              link_we,
    output logic [XLEN-1:0]   link_val
);
    typedef struct packed {
        logic [XLEN-1:0] npc;
        logic            red;
        logic            lwe;
        logic [XLEN-1:0] lval;
    } st_t;

    st_t st_d, st_q;

    logic [XLEN-1:0] seq_pc, far_tgt, mid_tgt, reg_tgt, tgt;
    logic            take, lnk;

    cbr_target_gen #(
        .XLEN(XLEN), .I16_W(I16_W), .I21_W(I21_W), .I26_W(I26_W)
    ) u_tgen (
        .cur_pc (cur_pc),
        .rt_val (rt_val),
        .imm16  (imm16),
        .imm21  (imm21),
        .imm26  (imm26),
        .seq_pc (seq_pc),
        .far_tgt(far_tgt),
        .mid_tgt(mid_tgt),
        .reg_tgt(reg_tgt)
    );

    cbr_resolve #(.XLEN(XLEN), .RNUM_W(RNUM_W)) u_res (
        .op_class(op_class),
        .link_sel(link_sel),
        .rs_num  (rs_num),
        .rs_val  (rs_val),
        .far_tgt (far_tgt),
        .mid_tgt (mid_tgt),
        .reg_tgt (reg_tgt),
        .take    (take),
        .lnk     (lnk),
        .tgt     (tgt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.red  = take;
        st_d.lwe  = lnk;
        st_d.npc  = take ? tgt : seq_pc;
        st_d.lval = seq_pc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_pc  = st_q.npc;
    assign redirect = st_q.red;
    assign link_we  = st_q.lwe;
    assign link_val = st_q.lval;
endmodule

// File: rtl/cbr_next_pc_chk.sv
module cbr_next_pc_chk #(
    parameter int XLEN   = 32,
    parameter int RNUM_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_class,
    input logic              link_sel,
    input logic [XLEN-1:0]   cur_pc,
    input logic [XLEN-1:0]   rs_val,
    input logic [RNUM_W-1:0] rs_num,
    input logic [XLEN-1:0]   next_pc,
    input logic              redirect,
    input logic              link_we,
    input logic [XLEN-1:0]   link_val
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!redirect && !link_we && next_pc == '0 && link_val == '0));

    p_uncond_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_class) == 3'd1) |-> (redirect && !link_we));

    p_link_val_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (link_val == $past(cur_pc) + XLEN'(4)));

    p_zero_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_class) == 3'd3 && $past(rs_num) != '0
         && $past(rs_val) == '0) |-> redirect);

    p_not_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_class) == 3'd3 && $past(rs_num) != '0
         && $past(rs_val) != '0) |-> (!redirect && next_pc == $past(cur_pc) + XLEN'(4)));

    p_zj_nolink_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_class) == 3'd3) |-> !link_we);

    p_link_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> ($past(op_class) == 3'd2 || ($past(op_class) == 3'd4 && $past(link_sel))));

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_class) == 3'd0 || $past(op_class) > 3'd4))
        |-> (!redirect && !link_we && next_pc == $past(cur_pc) + XLEN'(4)));
endmodule

bind cbr_next_pc cbr_next_pc_chk #(.XLEN(XLEN), .RNUM_W(RNUM_W)) u_chk (.*);

// File: tb/cbr_next_pc_tb.sv
module cbr_next_pc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_class = '0;
    logic        link_sel = 1'b0;
    logic [31:0] cur_pc = '0, rs_val = '0, rt_val = '0;
    logic [4:0]  rs_num = '0;
    logic [15:0] imm16 = '0;
    logic [20:0] imm21 = '0;
    logic [25:0] imm26 = '0;
    logic [31:0] next_pc, link_val;
    logic        redirect, link_we;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cbr_next_pc u_dut (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .link_sel(link_sel),
        .cur_pc(cur_pc), .rs_val(rs_val), .rt_val(rt_val), .rs_num(rs_num),
        .imm16(imm16), .imm21(imm21), .imm26(imm26),
        .next_pc(next_pc), .redirect(redirect), .link_we(link_we), .link_val(link_val)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic        ls;
        logic [31:0] pc;
        logic [31:0] rsv;
        logic [31:0] rtv;
        logic [4:0]  rsn;
        logic [15:0] i16;
        logic [20:0] i21;
        logic [25:0] i26;
        logic [31:0] enpc;
        logic        ered;
        logic        elwe;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{3'd1, 1'b0, 32'h0000_1000, 32'd0, 32'd0, 5'd0, 16'h0, 21'h0, 26'h000_0010, 32'h0000_1044, 1'b1, 1'b0}, // R2
        '{3'd1, 1'b0, 32'h0000_1000, 32'd0, 32'd0, 5'd0, 16'h0, 21'h0, 26'h3FF_FFFF, 32'h0000_1000, 1'b1, 1'b0}, // R2 R10
        '{3'd1, 1'b0, 32'h1000_0000, 32'd0, 32'd0, 5'd0, 16'h0, 21'h0, 26'h200_0000, 32'h0800_0004, 1'b1, 1'b0}, // R10
        '{3'd2, 1'b0, 32'h0000_2000, 32'd0, 32'd0, 5'd0, 16'h0, 21'h0, 26'h000_0100, 32'h0000_2404, 1'b1, 1'b1}, // R3
        '{3'd3, 1'b0, 32'h0000_3000, 32'd0, 32'd0, 5'd5, 16'h0, 21'h00020, 26'h0, 32'h0000_3084, 1'b1, 1'b0}, // R4
        '{3'd3, 1'b0, 32'h0000_3000, 32'd0, 32'd0, 5'd5, 16'h0, 21'h1FFFFF, 26'h0, 32'h0000_3000, 1'b1, 1'b0}, // R4 R10
        '{3'd3, 1'b0, 32'h0000_3000, 32'd7, 32'd0, 5'd5, 16'h0, 21'h00020, 26'h0, 32'h0000_3004, 1'b0, 1'b0}, // R5
        '{3'd3, 1'b1, 32'h0000_3000, 32'd9, 32'h0000_4000, 5'd0, 16'h0010, 21'h0, 26'h0, 32'h0000_4010, 1'b1, 1'b0}, // R6
        '{3'd3, 1'b0, 32'h0000_3000, 32'd0, 32'h0000_4000, 5'd0, 16'hFFF0, 21'h0, 26'h0, 32'h0000_3FF0, 1'b1, 1'b0}, // R6
        '{3'd4, 1'b0, 32'h0000_6000, 32'd0, 32'h0000_5000, 5'd0, 16'h8000, 21'h0, 26'h0, 32'hFFFF_D000, 1'b1, 1'b0}, // R7 R10
        '{3'd4, 1'b1, 32'h0000_6000, 32'd0, 32'h0000_7000, 5'd0, 16'h0004, 21'h0, 26'h0, 32'h0000_7004, 1'b1, 1'b1}, // R7
        '{3'd0, 1'b1, 32'h0000_8000, 32'd0, 32'h0000_7000, 5'd0, 16'h0004, 21'h0, 26'h1, 32'h0000_8004, 1'b0, 1'b0}, // R8
        '{3'd5, 1'b1, 32'h0000_8000, 32'd0, 32'h0000_7000, 5'd3, 16'h0004, 21'h1, 26'h1, 32'h0000_8004, 1'b0, 1'b0}, // R8
        '{3'd7, 1'b0, 32'h0000_9000, 32'd0, 32'd0, 5'd0, 16'h0, 21'h0, 26'h1, 32'h0000_9004, 1'b0, 1'b0}, // R8
        '{3'd1, 1'b0, 32'hFFFF_FFFC, 32'd0, 32'd0, 5'd0, 16'h0, 21'h0, 26'h0, 32'h0000_0000, 1'b1, 1'b0}  // R10
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        op_class = v.op;  link_sel = v.ls;  cur_pc = v.pc;
        rs_val = v.rsv;   rt_val = v.rtv;   rs_num = v.rsn;
        imm16 = v.i16;    imm21 = v.i21;    imm26 = v.i26;
    endtask

    initial begin
        #3_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: inputs active during reset must not reach the outputs
        apply(VT[3]);
        repeat (3) @(negedge clk);
        chk("R1", "next_pc", next_pc, 32'h0);
        chk("R1", "redirect", {31'd0, redirect}, 32'd0);
        chk("R1", "link_we", {31'd0, link_we}, 32'd0);
        chk("R1", "link_val", link_val, 32'h0);
        rst_n = 1'b1;

        // R2-R8, R10: vector table
        for (int i = 0; i < NV; i++) begin
            apply(VT[i]);
            @(negedge clk);
            chk($sformatf("vec%0d", i), "next_pc", next_pc, VT[i].enpc);
            chk($sformatf("vec%0d", i), "redirect", {31'd0, redirect}, {31'd0, VT[i].ered});
            chk($sformatf("vec%0d", i), "link_we", {31'd0, link_we}, {31'd0, VT[i].elwe});
            chk("R3", "link_val", link_val, VT[i].pc + 32'd4);
        end

        // R9: new inputs do not show before the next rising edge
        apply(VT[0]);
        @(negedge clk);
        apply(VT[6]);
        #2;
        chk("R9", "next_pc held", next_pc, 32'h0000_1044);
        chk("R9", "redirect held", {31'd0, redirect}, 32'd1);
        @(negedge clk);
        chk("R9", "next_pc updated", next_pc, 32'h0000_3004);
        chk("R9", "redirect updated", {31'd0, redirect}, 32'd0);

        // R6: link_sel on the shared jump opcode writes no link, back to back with a linking jump
        apply(VT[10]);
        @(negedge clk);
        chk("R7", "link_we", {31'd0, link_we}, 32'd1);
        chk("R7", "link_val", link_val, 32'h0000_6004);
        apply(VT[7]);
        @(negedge clk);
        chk("R6", "link_we", {31'd0, link_we}, 32'd0);
        chk("R6", "next_pc", next_pc, 32'h0000_4010);

        // R4 boundary: rs_val with only the top bit set is nonzero
        apply(VT[4]);
        rs_val = 32'h8000_0000;
        @(negedge clk);
        chk("R5", "redirect", {31'd0, redirect}, 32'd0);
        chk("R5", "next_pc", next_pc, 32'h0000_3004);

        // R1: reset asserted mid-run clears the outputs
        apply(VT[3]);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "redirect mid-run", {31'd0, redirect}, 32'd0);
        chk("R1", "link_we mid-run", {31'd0, link_we}, 32'd0);
        chk("R1", "next_pc mid-run", next_pc, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3", "after reset", next_pc, 32'h0000_2404);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule